// File: doc/BRIEF.md
# Dual-Channel Peripheral-to-Memory Transfer Engine

This block services two peripheral ports on behalf of a processor, moving one item per service request between each port and its own memory buffer. When a request is pending, a status input tells the engine which port is asking. The engine reads that port's data register, and the peripheral drops its request when it sees the read. The engine then writes the item to the channel's current buffer address through a single-beat memory master and advances that channel's pointer. A transfer run stops as soon as either channel's pointer lands on its programmed end address, and a sticky done flag is raised.

Software sets the engine up through a small write-only configuration port:

| Select | Contents |
|---|---|
| 0 | Control: bit0 enable, bit1 byte mode, bit2 single-channel, bit3 memory-to-port direction |
| 1 | Channel 1 pointer |
| 2 | Channel 1 end address |
| 3 | Channel 2 pointer |
| 4 | Channel 2 end address |
| 5 | Clear done (the data is ignored) |

In the memory-to-port direction, the engine reads the buffer first and then writes the port's data register. The port write is what clears that port's request.

Top module: `dual_xfer_engine`

## Requirements
- R1: After reset, done is 0 and mem_req, p1_rd, p2_rd, p1_wr and p2_wr are all 0.
- R2: In dual-channel mode a service uses port 1 and the channel 1 pointer when port1_active is 1, and port 2 and the channel 2 pointer when it is 0.
- R3: Each service strobes the chosen port's read (or write) line for exactly one cycle, and at most one of the four port strobes is high in any cycle.
- R4: In word mode a memory write carries the full 32-bit item with mem_be = 4'b1111, and the channel pointer advances by 4 after the write.
- R5: In byte mode mem_be is one-hot at bit position mem_addr[1:0], the low byte of the item is repeated on all four byte lanes, and the pointer advances by 1.
- R6: mem_req, mem_addr and mem_wdata stay unchanged while mem_ready is 0. The pointer advances only in the cycle where mem_req and mem_ready are both 1.
- R7: When an advanced pointer equals its channel's end address, done goes to 1 and stays at 1. While done is 1, no request is serviced and the pending request stays high.
- R8: A write to select 5 clears done. If that write falls in the same cycle as a completion, done stays at 1.
- R9: A configuration write to a pointer takes precedence over an advance of that pointer in the same cycle. The access already in flight keeps its latched address.
- R10: In single-channel mode only port 1 is served, whatever port1_active says, and requests on port 2 are ignored.
- R11: With the direction bit set, each service first reads memory (mem_we = 0) at the channel pointer, then writes the result to the port through port_wdata. In byte mode that result is the byte lane picked by mem_addr[1:0], zero-extended.
- R12: With the enable bit at 0, no request is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| port1_active | input | 1 | Status: 1 means port 1 is requesting |
| req1 | input | 1 | Port 1 service request |
| req2 | input | 1 | Port 2 service request |
| p1_rdata | input | DW | Port 1 data register |
| p2_rdata | input | DW | Port 2 data register |
| p1_rd | output | 1 | Port 1 data read strobe |
| p2_rd | output | 1 | Port 2 data read strobe |
| p1_wr | output | 1 | Port 1 data write strobe |
| p2_wr | output | 1 | Port 2 data write strobe |
| port_wdata | output | DW | Data written to a port |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Byte enables |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| done | output | 1 | Sticky completion flag |

## Verification
Two cases put two functions in the same cycle.

The first is a completing memory write and a software clear of done. The bench holds mem_ready low until the final access is waiting, then raises mem_ready in the same cycle as a select-5 write. It then expects done to read 1.

The second is a pointer advance and a software pointer write. The bench lines them up the same way. It expects the in-flight write at the old address and the next service at the newly written address.

// File: rtl/dual_xfer_engine.sv
module dual_xfer_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          port1_active,
  input  logic          req1,
  input  logic          req2,
  input  logic [DW-1:0] p1_rdata,
  input  logic [DW-1:0] p2_rdata,
  output logic          p1_rd,
  output logic          p2_rd,
  output logic          p1_wr,
  output logic          p2_wr,
  output logic [DW-1:0] port_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done
);
  localparam int NB = DW / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE, ST_PUT} st_t;

  st_t st;
  logic en, byte_md, single, to_port, ch, done_q;
  logic [AW-1:0] ptr1, ptr2, end1, end2, maddr;
  logic [DW-1:0] data_q;

  wire          pick    = single ? 1'b1 : port1_active;
  wire          go      = en && !done_q && (req1 || (!single && req2));
  wire [AW-1:0] step    = byte_md ? AW'(1) : AW'(NB);
  wire [AW-1:0] nxt     = maddr + step;
  wire [AW-1:0] end_cur = ch ? end1 : end2;
  wire          accept  = (st == ST_MOVE) && mem_ready;
  wire          hit     = accept && (nxt == end_cur);
  wire [LW-1:0] lane    = maddr[LW-1:0];
  wire [DW-1:0] shifted = mem_rdata >> {lane, 3'b000};
  wire [DW-1:0] rd_item = byte_md ? {{(DW-8){1'b0}}, shifted[7:0]} : mem_rdata;
  wire [NB-1:0] be_one  = {{(NB-1){1'b0}}, 1'b1} << lane;

  assign p1_rd      = (st == ST_FETCH) && ch;
  assign p2_rd      = (st == ST_FETCH) && !ch;
  assign p1_wr      = (st == ST_PUT) && ch;
  assign p2_wr      = (st == ST_PUT) && !ch;
  assign port_wdata = data_q;
  assign mem_req    = (st == ST_MOVE);
  assign mem_we     = !to_port;
  assign mem_addr   = maddr;
  assign mem_wdata  = byte_md ? {NB{data_q[7:0]}} : data_q;
  assign mem_be     = byte_md ? be_one : {NB{1'b1}};
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {en, byte_md, single, to_port} <= '0;
      ch <= 1'b0;
      done_q <= 1'b0;
      ptr1 <= '0; ptr2 <= '0; end1 <= '0; end2 <= '0;
      maddr <= '0;
      data_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          ch    <= pick;
          maddr <= pick ? ptr1 : ptr2;
          st    <= to_port ? ST_MOVE : ST_FETCH;
        end
        ST_FETCH: begin
          data_q <= ch ? p1_rdata : p2_rdata;
          st     <= ST_MOVE;
        end
        ST_MOVE: if (mem_ready) begin
          if (ch) ptr1 <= nxt;
          else    ptr2 <= nxt;
          if (to_port) begin
            data_q <= rd_item;
            st     <= ST_PUT;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (cfg_we) begin
        case (cfg_sel)
          3'd0: {to_port, single, byte_md, en} <= cfg_wdata[3:0];
          3'd1: ptr1 <= cfg_wdata;
          3'd2: end1 <= cfg_wdata;
          3'd3: ptr2 <= cfg_wdata;
          3'd4: end2 <= cfg_wdata;
          3'd5: done_q <= 1'b0;
          default: ;
        endcase
      end
      if (hit) done_q <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !done && !mem_req && !p1_rd && !p2_rd); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({p1_rd, p2_rd, p1_wr, p2_wr})); // R3
  AST_WORD_BE: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !byte_md |-> $countones(mem_be) == NB); // R4
  AST_BYTE_BE: assert property (@(posedge clk) disable iff (!rst_n) mem_req && byte_md |-> $countones(mem_be) == 1); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R6
  AST_DONE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_req && !p1_rd && !p2_rd); // R7
  AST_SINGLE_P1: assert property (@(posedge clk) disable iff (!rst_n) single && $stable(single) |-> !p2_rd && !p2_wr); // R10
endmodule

// File: tb/tb_dual_xfer_engine.sv
`timescale 1ns/1ps
module tb_dual_xfer_engine;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic port1_active = 0, req1 = 0, req2 = 0;
  logic [31:0] p1_rdata = 0, p2_rdata = 0, mem_rdata = 0;
  logic mem_ready = 1;
  logic p1_rd, p2_rd, p1_wr, p2_wr, mem_req, mem_we, done;
  logic [31:0] port_wdata, mem_addr, mem_wdata;
  logic [3:0] mem_be;

  always #10 clk = ~clk;

  dual_xfer_engine dut (.*);

  typedef struct {
    int kind;
    logic [31:0] addr;
    logic [3:0] be;
    logic [31:0] data;
    int port;
    string tag;
  } item_t;

  item_t q[$];
  item_t mit;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] held;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_w(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
    item_t it;
    it.kind = 0; it.addr = a; it.be = be; it.data = d; it.port = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_r(input logic [31:0] a, input string tag);
    item_t it;
    it.kind = 1; it.addr = a; it.be = 0; it.data = 0; it.port = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_p(input int p, input logic [31:0] d, input string tag);
    item_t it;
    it.kind = 2; it.addr = 0; it.be = 0; it.data = d; it.port = p; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cfg(input logic [2:0] s, input logic [31:0] v);
    @(posedge clk); #2;
    cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic raise(input int p, input logic [31:0] d, input logic stat);
    @(posedge clk); #2;
    port1_active = stat;
    if (p == 1) begin p1_rdata = d; req1 = 1; end
    else begin p2_rdata = d; req2 = 1; end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  // monitor: compares every memory acceptance and port write against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ready) begin
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected memory access actual=%h expected=none", mem_addr);
        end else begin
          mit = q.pop_front();
          if (mit.kind == 0 && !(mem_we && mem_addr == mit.addr && mem_be == mit.be && mem_wdata == mit.data)) begin
            n_fail++;
            $display("FAIL %s write actual=%h/%b/%h expected=%h/%b/%h", mit.tag,
                     mem_addr, mem_be, mem_wdata, mit.addr, mit.be, mit.data);
          end else if (mit.kind == 1 && !(!mem_we && mem_addr == mit.addr)) begin
            n_fail++;
            $display("FAIL %s read actual=%h we=%b expected=%h", mit.tag, mem_addr, mem_we, mit.addr);
          end else if (mit.kind == 2) begin
            n_fail++;
            $display("FAIL %s actual=memory access expected=port write", mit.tag);
          end
        end
      end
      if (p1_wr || p2_wr) begin
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected port write actual=%h expected=none", port_wdata);
        end else begin
          mit = q.pop_front();
          if (!(mit.kind == 2 && port_wdata == mit.data && (p1_wr ? 1 : 2) == mit.port)) begin
            n_fail++;
            $display("FAIL %s port write actual=%h expected=%h", mit.tag, port_wdata, mit.data);
          end
        end
      end
      if (p1_rd || p1_wr) req1 = 0;
      if (p2_rd || p2_wr) req2 = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !mem_req && !p1_rd && !p2_rd && !p1_wr && !p2_wr, "R1 reset",
        {done, mem_req, p1_rd, p2_rd}, 0);

    // R12 disabled engine ignores requests
    cfg(1, 32'h100); cfg(2, 32'h200); cfg(3, 32'h1000); cfg(4, 32'h1100);
    raise(1, 32'h0BAD0BAD, 1);
    repeat (8) @(negedge clk);
    chk(req1 == 1, "R12 request pending while disabled", req1, 1);
    cfg(0, 32'h1);
    push_w(32'h100, 4'hF, 32'h0BAD0BAD, "R12 served after enable");
    drain("R12 drain");

    // R2, R4 status selects port and buffer
    raise(1, 32'h11111111, 1);
    push_w(32'h104, 4'hF, 32'h11111111, "R2 port1 to buffer1");
    drain("R2 drain a");
    raise(2, 32'h22222222, 0);
    push_w(32'h1000, 4'hF, 32'h22222222, "R2 port2 to buffer2");
    drain("R2 drain b");
    chk(req2 == 0, "R3 port2 request cleared by read", req2, 0);

    // R6 stall
    mem_ready = 0;
    raise(1, 32'h33333333, 1);
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    held = mem_addr;
    repeat (3) begin
      @(negedge clk);
      chk(mem_req && mem_addr == held, "R6 request held during stall", mem_addr, held);
    end
    push_w(32'h108, 4'hF, 32'h33333333, "R4 word step of 4");
    @(posedge clk); #2 mem_ready = 1;
    drain("R6 drain");
    raise(1, 32'h44444444, 1);
    push_w(32'h10C, 4'hF, 32'h44444444, "R6 single advance per accept");
    drain("R6 drain b");

    // R7 completion and halt
    cfg(3, 32'h10F8); cfg(4, 32'h10FC);
    raise(2, 32'h55555555, 0);
    push_w(32'h10F8, 4'hF, 32'h55555555, "R7 last write");
    drain("R7 drain");
    chk(done == 1, "R7 done raised", done, 1);
    raise(1, 32'h66666666, 1);
    repeat (10) @(negedge clk);
    chk(req1 == 1 && done == 1, "R7 request held while done", {req1, done}, 2'b11);
    // R8 clear
    push_w(32'h110, 4'hF, 32'h66666666, "R8 served after clear");
    cfg(5, 0);
    drain("R8 drain");
    chk(done == 0, "R8 done cleared", done, 0);

    // R8 clear collides with completion
    cfg(1, 32'h400); cfg(2, 32'h404);
    mem_ready = 0;
    raise(1, 32'h77777777, 1);
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    push_w(32'h400, 4'hF, 32'h77777777, "R8 colliding write");
    @(posedge clk); #2;
    mem_ready = 1; cfg_we = 1; cfg_sel = 5; cfg_wdata = 0;
    @(posedge clk); #2 cfg_we = 0;
    @(negedge clk);
    chk(done == 1, "R8 set wins over clear", done, 1);
    drain("R8 drain b");
    cfg(5, 0);
    @(negedge clk);
    chk(done == 0, "R8 cleared later", done, 0);

    // R9 pointer write collides with advance
    cfg(1, 32'h500); cfg(2, 32'h600);
    mem_ready = 0;
    raise(1, 32'h88888888, 1);
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    push_w(32'h500, 4'hF, 32'h88888888, "R9 in-flight keeps address");
    @(posedge clk); #2;
    mem_ready = 1; cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'h540;
    @(posedge clk); #2 cfg_we = 0;
    drain("R9 drain");
    raise(1, 32'h99999999, 1);
    push_w(32'h540, 4'hF, 32'h99999999, "R9 software pointer wins");
    drain("R9 drain b");

    // R5 byte mode
    cfg(0, 32'h3); cfg(1, 32'h301); cfg(2, 32'h3FF);
    raise(1, 32'h123456AB, 1);
    push_w(32'h301, 4'b0010, 32'hABABABAB, "R5 byte lane 1");
    drain("R5 drain");
    raise(1, 32'h000000CD, 1);
    push_w(32'h302, 4'b0100, 32'hCDCDCDCD, "R5 byte step of 1");
    drain("R5 drain b");

    // R10 single-channel
    cfg(0, 32'h5); cfg(1, 32'h900); cfg(2, 32'h9F0);
    raise(2, 32'hEEEEEEEE, 0);
    repeat (8) @(negedge clk);
    chk(req2 == 1, "R10 port2 ignored", req2, 1);
    raise(1, 32'hFACEFACE, 0);
    push_w(32'h900, 4'hF, 32'hFACEFACE, "R10 port1 served despite status");
    drain("R10 drain");
    chk(req2 == 1, "R10 port2 still pending", req2, 1);
    @(posedge clk); #2 req2 = 0;

    // R11 memory to port
    cfg(0, 32'h9); cfg(1, 32'h700); cfg(2, 32'h800);
    mem_rdata = 32'hCAFEF00D;
    raise(1, 0, 1);
    push_r(32'h700, "R11 word read");
    push_p(1, 32'hCAFEF00D, "R11 word to port1");
    drain("R11 drain");
    chk(req1 == 0, "R11 port write clears request", req1, 0);
    cfg(0, 32'hB); cfg(3, 32'h803); cfg(4, 32'h8FF);
    mem_rdata = 32'h11223344;
    raise(2, 0, 0);
    push_r(32'h803, "R11 byte read");
    push_p(2, 32'h00000011, "R11 byte lane 3 to port2");
    drain("R11 drain b");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule